// File: doc/BRIEF.md
# Synchronous Burst Cache Data RAM

This block is a clocked single-port memory of 18-bit words meant to serve as the data store of a cache that fills and drains lines in bursts of four. Every input except the output enable is captured on the rising clock edge. A cycle in which one of two transfer-start strobes is low loads a base address. After that, the two low address bits come from an internal wrapping counter, so a line of four words can be read or written without presenting the address again.

The two start strobes differ. The processor-side strobe takes priority and always begins a read. The controller-side strobe begins a read or a write, depending on the byte write enables. Between starts, an advance input either steps the counter before the access or holds it to insert a wait state. Chip enable is looked at only on start cycles. Each 18-bit word is written in two 9-bit halves under separate enables.

The bidirectional data pin is replaced by a data input, a data output and a drive flag. The drive flag follows the output enable without the clock.

Top module: `burst_sram`

## Requirements
- R1: A synchronous active-high reset leaves the block deselected. After reset `dout_drive` is 0, and continue or suspend cycles perform no access until a start cycle with chip enable low occurs.
- R2: A processor-side start (`ts_cpu_n` low) with `ce_n` low loads `addr` and performs a read of that address. This holds whatever the levels of `ts_ctl_n`, `wen_lo_n` and `wen_hi_n`, and it abandons any burst in progress.
- R3: A controller-side start (`ts_ctl_n` low, `ts_cpu_n` high) with `ce_n` low loads `addr`. It writes if `wen_lo_n` or `wen_hi_n` is low, and reads otherwise.
- R4: A start cycle with `ce_n` high deselects the block. While deselected, `dout_drive` stays 0, and continue or suspend cycles write nothing to memory.
- R5: With both strobes high and `adv_n` low, a selected block adds one, modulo 4, to the two low address bits before the access. The access is a write if either write enable is low, otherwise a read.
- R6: With both strobes high and `adv_n` high, a selected block repeats the access at the current address (wait state).
- R7: Only address bits 1:0 are counted. The upper bits keep the loaded value, so the fifth step of a burst returns to the starting word, for any of the four starting values.
- R8: `wen_lo_n` low writes `din[8:0]` and `wen_hi_n` low writes `din[17:9]`. A half whose enable is high keeps its old content.
- R9: A processor-side start followed by a cycle with both strobes high, `adv_n` high and a write enable low writes `din` to the loaded address.
- R10: `dout_drive` equals "the previous clock edge sampled a selected read" AND `oe_n` low, and it follows `oe_n` without a clock edge. While it is 1, `dout` carries the word read; after a write edge it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address, loaded on start cycles |
| ts_cpu_n | input | 1 | Processor-side transfer start, active low, read only |
| ts_ctl_n | input | 1 | Controller-side transfer start, active low |
| adv_n | input | 1 | Burst advance, active low; high inserts a wait state |
| ce_n | input | 1 | Chip enable, active low, sampled on start cycles only |
| wen_lo_n | input | 1 | Write enable for data bits 8:0, active low |
| wen_hi_n | input | 1 | Write enable for data bits 17:9, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | 18 | Write data |
| dout | output | 18 | Read data, zero when not driven |
| dout_drive | output | 1 | High when `dout` would drive the bus |

## Verification
Writes take effect at the sampling edge, so the first read that can observe them is a later access. Read data and the registered part of the drive flag are due one clock after the edge that samples the read. The bench drives each cycle's inputs at the falling edge, lets one rising edge pass, and compares `dout` and `dout_drive` at the next falling edge, before changing anything. The asynchronous part of R10 is checked by toggling `oe_n` between two clock edges and sampling after a short delay, with no clock edge in between.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } bsr_op_e;

  // low two address bits after an optional advance (modulo 4)
  function automatic logic [1:0] step_low(input logic [1:0] cur, input logic adv_n);
    return cur + {1'b0, ~adv_n};
  endfunction

  // a cycle writes when any half-word enable is active
  function automatic logic any_write(input logic lo_n, input logic hi_n);
    return ~(lo_n & hi_n);
  endfunction

endpackage

// File: rtl/burst_seq.sv
module burst_seq
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ts_cpu_n,
  input  logic              ts_ctl_n,
  input  logic              adv_n,
  input  logic              ce_n,
  input  logic              wen_lo_n,
  input  logic              wen_hi_n,
  output bsr_op_e           acc_op,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              load_evt
);
  localparam int HI_W = ADDR_W - 2;

  logic            sel_q;
  logic [HI_W-1:0] hi_q;
  logic [1:0]      low_q;

  assign load_evt = ~ts_cpu_n | ~ts_ctl_n;

  always_comb begin
    acc_op   = OP_IDLE;
    acc_addr = {hi_q, low_q};
    if (load_evt) begin
      acc_addr = addr;
      if (!ce_n) begin
        if (!ts_cpu_n) acc_op = OP_READ;
        else           acc_op = any_write(wen_lo_n, wen_hi_n) ? OP_WRITE : OP_READ;
      end
    end else if (sel_q) begin
      acc_addr = {hi_q, step_low(low_q, adv_n)};
      acc_op   = any_write(wen_lo_n, wen_hi_n) ? OP_WRITE : OP_READ;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      hi_q  <= '0;
      low_q <= 2'd0;
    end else if (load_evt) begin
      sel_q <= ~ce_n;
      hi_q  <= addr[ADDR_W-1:2];
      low_q <= addr[1:0];
    end else if (sel_q) begin
      low_q <= acc_addr[1:0];
    end
  end

endmodule

// File: rtl/burst_array.sv
module burst_array #(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 9
) (
  input  logic                clk,
  input  logic                re,
  input  logic [1:0]          we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2*HALF_W-1:0] wdata,
  output logic [2*HALF_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NHALF = 2;

  for (genvar g = 0; g < NHALF; g++) begin : g_half
    logic [HALF_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) mem[addr] <= wdata[g*HALF_W +: HALF_W];
      if (re)    rdata[g*HALF_W +: HALF_W] <= mem[addr];
    end
  end

endmodule

// File: rtl/burst_outstage.sv
module burst_outstage #(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_evt,
  input  logic              oe_n,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] dout,
  output logic              dout_drive
);
  logic rd_q;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= rd_evt;
  end

  assign dout_drive = rd_q & ~oe_n;
  assign dout       = dout_drive ? rdata : '0;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                ts_cpu_n,
  input  logic                ts_ctl_n,
  input  logic                adv_n,
  input  logic                ce_n,
  input  logic                wen_lo_n,
  input  logic                wen_hi_n,
  input  logic                oe_n,
  input  logic [2*HALF_W-1:0] din,
  output logic [2*HALF_W-1:0] dout,
  output logic                dout_drive
);
  localparam int WORD_W = 2 * HALF_W;

  bsr_op_e             acc_op;
  logic [ADDR_W-1:0]   acc_addr;
  logic                load_evt;
  logic                acc_en;
  logic                acc_wr;
  logic [1:0]          half_we;
  logic [WORD_W-1:0]   rdata;

  burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .ts_cpu_n (ts_cpu_n),
    .ts_ctl_n (ts_ctl_n),
    .adv_n    (adv_n),
    .ce_n     (ce_n),
    .wen_lo_n (wen_lo_n),
    .wen_hi_n (wen_hi_n),
    .acc_op   (acc_op),
    .acc_addr (acc_addr),
    .load_evt (load_evt)
  );

  assign acc_en  = (acc_op != OP_IDLE);
  assign acc_wr  = (acc_op == OP_WRITE);
  assign half_we = {acc_wr & ~wen_hi_n, acc_wr & ~wen_lo_n};

  burst_array #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_array (
    .clk   (clk),
    .re    (acc_op == OP_READ),
    .we    (half_we),
    .addr  (acc_addr),
    .wdata (din),
    .rdata (rdata)
  );

  burst_outstage #(.WORD_W(WORD_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .rd_evt     (acc_op == OP_READ),
    .oe_n       (oe_n),
    .rdata      (rdata),
    .dout       (dout),
    .dout_drive (dout_drive)
  );

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ts_cpu_n,
  input logic              ce_n,
  input logic              adv_n,
  input logic              oe_n,
  input logic              dout_drive,
  input logic              load_evt,
  input logic              acc_en,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr
);

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !dout_drive); // R1

  AST_CPU_START_READS: assert property (@(posedge clk) disable iff (rst)
    (!ts_cpu_n && !ce_n) |-> (acc_en && !acc_wr)); // R2

  AST_CPU_START_SHOWS: assert property (@(posedge clk) disable iff (rst)
    (!ts_cpu_n && !ce_n) |=> (dout_drive || oe_n)); // R2

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (load_evt && ce_n) |=> !dout_drive); // R4

  AST_STEP_ON_ADV: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !load_evt && !adv_n) |-> ((acc_addr[1:0] - $past(acc_addr[1:0])) == 2'd1)); // R5

  AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !load_evt && adv_n) |-> (acc_addr == $past(acc_addr))); // R6

  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !load_evt) |-> (acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2]))); // R7

  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
    dout_drive |-> !oe_n); // R10

endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ts_cpu_n   (ts_cpu_n),
  .ce_n       (ce_n),
  .adv_n      (adv_n),
  .oe_n       (oe_n),
  .dout_drive (dout_drive),
  .load_evt   (load_evt),
  .acc_en     (acc_en),
  .acc_wr     (acc_wr),
  .acc_addr   (acc_addr)
);

// File: tb/tb_burst_sram.sv
module tb_burst_sram;
  localparam time CLK_T = 20ns;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  addr;
  logic        ts_cpu_n, ts_ctl_n, adv_n, ce_n, wen_lo_n, wen_hi_n, oe_n;
  logic [17:0] din;
  logic [17:0] dout;
  logic        dout_drive;

  int total = 0;
  int bad   = 0;

  // bench reference state, base + offset form
  logic [17:0] ref_mem [256];
  logic        m_sel;
  logic [7:0]  m_base;
  logic [1:0]  m_off;
  logic        m_rd;
  logic [17:0] m_q;

  always #(CLK_T/2) clk = ~clk;

  burst_sram dut (
    .clk(clk), .rst(rst), .addr(addr), .ts_cpu_n(ts_cpu_n), .ts_ctl_n(ts_ctl_n),
    .adv_n(adv_n), .ce_n(ce_n), .wen_lo_n(wen_lo_n), .wen_hi_n(wen_hi_n),
    .oe_n(oe_n), .din(din), .dout(dout), .dout_drive(dout_drive)
  );

  // vector: {req[3:0], exp_drive, cpu_n, ctl_n, adv_n, ce_n, wlo_n, whi_n, oe_n, addr[7:0], din[17:0]}
  localparam int NV = 14;
  localparam logic [37:0] VEC [NV] = '{
    {4'd3,  1'b0, 7'b1010000, 8'h14, 18'h11111},
    {4'd5,  1'b0, 7'b1100000, 8'h00, 18'h22222},
    {4'd5,  1'b0, 7'b1100000, 8'h00, 18'h33333},
    {4'd5,  1'b0, 7'b1100000, 8'h00, 18'h04444},
    {4'd7,  1'b0, 7'b1100000, 8'h00, 18'h05555},
    {4'd3,  1'b1, 7'b1010110, 8'h16, 18'h00000},
    {4'd5,  1'b1, 7'b1100110, 8'h00, 18'h00000},
    {4'd6,  1'b1, 7'b1110110, 8'h00, 18'h00000},
    {4'd7,  1'b1, 7'b1100110, 8'h00, 18'h00000},
    {4'd2,  1'b1, 7'b0010000, 8'h15, 18'h3ABCD},
    {4'd10, 1'b0, 7'b1100111, 8'h00, 18'h00000},
    {4'd4,  1'b0, 7'b1011110, 8'h15, 18'h00000},
    {4'd4,  1'b0, 7'b1100000, 8'h00, 18'h3FFFF},
    {4'd2,  1'b1, 7'b0110110, 8'h16, 18'h00000}
  };

  function automatic string rname(input logic [3:0] n);
    case (n)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input logic [17:0] act, input logic [17:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock cycle: drive at falling edge, step the model, check at next falling edge
  task automatic cyc(input logic [6:0] c, input logic [7:0] a, input logic [17:0] d, input string tag);
    logic wr;
    logic [7:0] ma;
    {ts_cpu_n, ts_ctl_n, adv_n, ce_n, wen_lo_n, wen_hi_n, oe_n} = c;
    addr = a; din = d;
    wr = 1'b0;
    if (!c[6] || !c[5]) begin
      m_sel = !c[3];
      if (m_sel) begin m_base = a; m_off = 2'd0; wr = c[6] && !(c[2] && c[1]); end
    end else if (m_sel) begin
      if (!c[4]) m_off = m_off + 2'd1;
      wr = !(c[2] && c[1]);
    end
    ma = {m_base[7:2], 2'(m_base[1:0] + m_off)};
    m_rd = m_sel && !wr;
    if (m_sel && wr) begin
      if (!c[2]) ref_mem[ma][8:0]  = d[8:0];
      if (!c[1]) ref_mem[ma][17:9] = d[17:9];
    end
    if (m_rd) m_q = ref_mem[ma];
    @(posedge clk);
    @(negedge clk);
    check({17'd0, dout_drive}, {17'd0, m_rd && !c[0]}, tag);
    if (m_rd && !c[0] && !$isunknown(m_q)) check(dout, m_q, tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    {ts_cpu_n, ts_ctl_n, adv_n, ce_n, wen_lo_n, wen_hi_n, oe_n} = 7'b1111110;
    addr = '0; din = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_sel = 1'b0; m_rd = 1'b0; m_off = 2'd0; m_base = '0;
  endtask

  initial begin
    #(CLK_T * 20000);
    bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = 'x;
    @(negedge clk);
    do_reset();
    // R1: reset state, and a continue cycle right after reset does nothing
    check({17'd0, dout_drive}, 18'd0, "R1");
    cyc(7'b1100110, 8'h00, 18'h0, "R1");

    // table walk
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][32:26], VEC[i][25:18], VEC[i][17:0], rname(VEC[i][37:34]));
      check({17'd0, dout_drive}, {17'd0, VEC[i][33]}, rname(VEC[i][37:34]));
    end

    // R7: wrap order from each of the four start points
    for (int k = 0; k < 4; k++)
      cyc(7'b1010000, 8'h40 + 8'(k), 18'h1000 + 18'(k), "R7");
    for (int s = 0; s < 4; s++) begin
      cyc(7'b0110110, 8'h40 + 8'(s), 18'h0, "R7");
      for (int j = 0; j < 4; j++) cyc(7'b1100110, 8'h0, 18'h0, "R7");
      check(dout, 18'h1000 + 18'(s), "R7");
    end

    // R6: several wait states in a row keep the word
    cyc(7'b0110110, 8'h42, 18'h0, "R6");
    cyc(7'b1110110, 8'h0, 18'h0, "R6");
    cyc(7'b1110110, 8'h0, 18'h0, "R6");
    check(dout, 18'h1002, "R6");

    // R8: half-word writes
    cyc(7'b1010000, 8'h50, 18'h3FFFF, "R8");
    cyc(7'b1010010, 8'h50, 18'h00000, "R8");
    cyc(7'b0110110, 8'h50, 18'h0, "R8");
    check(dout, 18'h3FE00, "R8");
    cyc(7'b1010100, 8'h50, 18'h00000, "R8");
    cyc(7'b0110110, 8'h50, 18'h0, "R8");
    check(dout, 18'h00000, "R8");

    // R9: two-cycle write after a processor-side start
    cyc(7'b0110000, 8'h60, 18'h12345, "R9");
    cyc(7'b1110000, 8'h00, 18'h2AAAA, "R9");
    cyc(7'b0110110, 8'h60, 18'h0, "R9");
    check(dout, 18'h2AAAA, "R9");

    // R2: processor-side start abandons a controller write burst and reads
    cyc(7'b1010000, 8'h70, 18'h0AAAA, "R2");
    cyc(7'b1100000, 8'h00, 18'h0BBBB, "R2");
    cyc(7'b0110000, 8'h43, 18'h3FFFF, "R2");
    check(dout, 18'h1003, "R2");
    cyc(7'b0110110, 8'h43, 18'h0, "R2");
    check(dout, 18'h1003, "R2");

    // R10: output enable acts without a clock edge
    cyc(7'b0110110, 8'h41, 18'h0, "R10");
    #1 oe_n = 1'b1;
    #1 check({17'd0, dout_drive}, 18'd0, "R10");
    oe_n = 1'b0;
    #1 check({17'd0, dout_drive}, 18'd1, "R10");
    check(dout, 18'h1001, "R10");
    @(negedge clk);
    // R10: write edge with oe low leaves the output undriven
    cyc(7'b1010000, 8'h80, 18'h00001, "R10");

    // R1: reset in the middle of a burst deselects
    cyc(7'b0110110, 8'h40, 18'h0, "R1");
    do_reset();
    check({17'd0, dout_drive}, 18'd0, "R1");
    cyc(7'b1100110, 8'h00, 18'h0, "R1");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule